// File: doc/BRIEF.md
# Picture-in-Picture Overlay Generator

This block produces the per-pixel overlay decision for a picture-in-picture display. A pixel counter runs on the 28 MHz display clock. The display horizontal sync clears it. A line counter advances on every horizontal sync, and the vertical sync clears it. From these two coordinates the block decodes four kinds of area:

- a background plane,
- a main inset window,
- a subchannel inset window,
- a thin rim (border) around each inset.

On every clock it reports three things: a fast-blanking flag, a region code, and the border or background colour that the video mixer further down the chain should insert.

Settings arrive on a simple parallel write port and land in a shadow bank. The shadow bank is copied into the live bank only when a vertical sync arrives, so a field is never drawn with half of its settings updated. Inset and rim sizes are elaboration parameters.

Top module: `pip_overlay`

## Requirements
- R1: After reset every setting is zero (background off, rims off, highlight off, every colour slot zero, every position zero) and both counters are zero, so the main window sits at the origin and covers the first pixel.
- R2: A vertical sync pulse clears both counters. A horizontal sync pulse without a vertical sync clears the pixel counter and adds one to the line counter. Otherwise the pixel counter adds one per clock. Both counters stop at their maximum value.
- R3: The write map is as follows:
  - Address 0: bit 0 enables the background, bit 1 enables the rims, bit 2 enables the sub-rim highlight.
  - Address 1: bits 6:5 pick a colour slot, bits 4:3 give the brightness, bits 2:0 give the colour type.
  - Address 2: bits 3:0 give the background horizontal offset, bits 7:4 give its vertical offset.
  - Addresses 3 and 4: main window horizontal and vertical position.
  - Addresses 5 and 6: subchannel window horizontal and vertical position.
- R4: A write changes nothing on the outputs until the next vertical sync. At that edge, every write made earlier becomes live at once, and the live settings hold steady between vertical syncs.
- R5: When enabled, the background covers 720 pixels starting at 4 × its horizontal offset and 240 lines starting at its vertical offset. When disabled, it draws nothing.
- R6: Each inset window starts at 8 × its horizontal position and at its vertical position. The main window is 160 × 60 and the subchannel window is 120 × 40.
- R7: When enabled, a rim 8 pixels wide at left and right and 2 lines tall at top and bottom surrounds each window. When disabled, no rim is drawn.
- R8: The region codes are 0 none, 1 background, 2 main rim, 3 sub rim, 4 main window and 5 sub window. The priority, from highest to lowest, is main window, sub window, main rim, sub rim, background.
- R9: The colour output is {brightness[1:0], type[2:0]}. Brightness codes 0 to 3 mean 30%, 50%, 70% and 100% IRE. Type codes 0 to 7 mean black/grey, blue, red, magenta, green, cyan, yellow and white/grey. Colour slot 0 feeds the main rim, slot 1 the sub rim and slot 2 the background. Inside a window or in no region the colour output is 0.
- R10: Slot 3 holds the highlight colour. While the highlight is enabled, the sub rim shows slot 3 instead of slot 1.
- R11: Fast blanking is high exactly when the region code is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 28 MHz display pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hSync | input | 1 | Display horizontal sync, one-clock active-high pulse |
| vSync | input | 1 | Display vertical sync, one-clock active-high pulse |
| wrEn | input | 1 | Write strobe for the setting port |
| wrAddr | input | 3 | Setting address |
| wrData | input | 8 | Setting data |
| fastBlank | output | 1 | High while the current pixel is in a drawn region |
| region | output | 3 | Region code of the current pixel |
| colour | output | 5 | Inserted colour {brightness, type} |

## Verification
The assertions assume that each sync arrives as a one-clock pulse sampled on the rising edge, and that the write port is quiet during reset. They also assume that a vertical sync is the only moment at which the live settings may change, so any other cycle must leave them untouched. The bench drives every input on the falling edge. It raises each sync for whole clock cycles only and never writes in the same cycle as a vertical sync. It positions the scan by issuing one vertical sync, then a chosen number of back-to-back horizontal syncs, then idle clocks up to the wanted pixel.

// File: rtl/pip_overlay_pkg.sv
package pip_overlay_pkg;

  typedef struct packed {
    logic [1:0] bright;
    logic [2:0] kind;
  } pipColour_t;

  typedef struct packed {
    logic             bgOn;
    logic             borderOn;
    logic             subHilite;
    pipColour_t [3:0] slot;
    logic [3:0]       bgH;
    logic [3:0]       bgV;
    logic [7:0]       mainH;
    logic [7:0]       mainV;
    logic [7:0]       subH;
    logic [7:0]       subV;
  } pipCfg_t;

  typedef struct packed {
    logic clrPx;
    logic clrLn;
    logic advLn;
  } pipStrobe_t;

  typedef enum logic [2:0] {
    RG_NONE     = 3'd0,
    RG_BG       = 3'd1,
    RG_MAIN_RIM = 3'd2,
    RG_SUB_RIM  = 3'd3,
    RG_MAIN_WIN = 3'd4,
    RG_SUB_WIN  = 3'd5
  } pipRegion_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_COLOUR = 3'd1;
  localparam logic [2:0] A_BGPOS  = 3'd2;
  localparam logic [2:0] A_MAIN_H = 3'd3;
  localparam logic [2:0] A_MAIN_V = 3'd4;
  localparam logic [2:0] A_SUB_H  = 3'd5;
  localparam logic [2:0] A_SUB_V  = 3'd6;

  localparam logic [1:0] SLOT_MAIN   = 2'd0;
  localparam logic [1:0] SLOT_SUB    = 2'd1;
  localparam logic [1:0] SLOT_BG     = 2'd2;
  localparam logic [1:0] SLOT_HILITE = 2'd3;

endpackage

// File: rtl/pip_rect_decode.sv
module pip_rect_decode #(
  parameter int HC    = 14,
  parameter int VC    = 12,
  parameter int W     = 160,
  parameter int H     = 60,
  parameter int RIM_W = 8,
  parameter int RIM_H = 2
) (
  input  logic [HC-1:0] px,
  input  logic [VC-1:0] ln,
  input  logic [HC-1:0] x0,
  input  logic [VC-1:0] y0,
  output logic          inWin,
  output logic          inRim
);
  logic outer;

  // window: [x0, x0+W) x [y0, y0+H)
  assign inWin = (px >= x0) && (px < x0 + HC'(W)) &&
                 (ln >= y0) && (ln < y0 + VC'(H));

  // outer box grown by the rim; rim width added on the left side of the
  // compare so that a window near the origin never underflows
  assign outer = (px + HC'(RIM_W) >= x0) && (px < x0 + HC'(W + RIM_W)) &&
                 (ln + VC'(RIM_H) >= y0) && (ln < y0 + VC'(H + RIM_H));

  assign inRim = outer && !inWin;
endmodule

// File: rtl/pip_overlay_ctrl.sv
module pip_overlay_ctrl
  import pip_overlay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hSync,
  input  logic       vSync,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  output pipStrobe_t strb,
  output pipCfg_t    cfg
);
  pipCfg_t shadow;

  // shadow bank, written by the setting port (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          shadow.bgOn      <= wrData[0];
          shadow.borderOn  <= wrData[1];
          shadow.subHilite <= wrData[2];
        end
        A_COLOUR: shadow.slot[wrData[6:5]] <= wrData[4:0];
        A_BGPOS: begin
          shadow.bgH <= wrData[3:0];
          shadow.bgV <= wrData[7:4];
        end
        A_MAIN_H: shadow.mainH <= wrData;
        A_MAIN_V: shadow.mainV <= wrData;
        A_SUB_H:  shadow.subH  <= wrData;
        A_SUB_V:  shadow.subV  <= wrData;
        default: ;
      endcase
    end
  end

  // live bank follows the shadow only on vertical sync (R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfg <= '0;
    else if (vSync) cfg <= shadow;
  end

  // counter strobes toward the datapath (R2)
  always_comb begin
    strb.clrPx = hSync | vSync;
    strb.clrLn = vSync;
    strb.advLn = hSync & ~vSync;
  end
endmodule

// File: rtl/pip_overlay_dp.sv
module pip_overlay_dp
  import pip_overlay_pkg::*;
#(
  parameter int PX_BITS = 12,
  parameter int LN_BITS = 10,
  parameter int BG_W    = 720,
  parameter int BG_H    = 240,
  parameter int MAIN_W  = 160,
  parameter int MAIN_H  = 60,
  parameter int SUB_W   = 120,
  parameter int SUB_H   = 40,
  parameter int RIM_W   = 8,
  parameter int RIM_H   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  pipStrobe_t strb,
  input  pipCfg_t    cfg,
  output logic       fastBlank,
  output logic [2:0] region,
  output logic [4:0] colour
);
  localparam int HC = PX_BITS + 2;
  localparam int VC = LN_BITS + 2;
  localparam logic [PX_BITS-1:0] PX_MAX = '1;
  localparam logic [LN_BITS-1:0] LN_MAX = '1;

  logic [PX_BITS-1:0] px;
  logic [LN_BITS-1:0] ln;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      px <= '0;
      ln <= '0;
    end else begin
      if (strb.clrPx)        px <= '0;
      else if (px != PX_MAX) px <= px + 1'b1;
      if (strb.clrLn)                       ln <= '0;
      else if (strb.advLn && ln != LN_MAX) ln <= ln + 1'b1;
    end
  end

  logic [HC-1:0] pxE;
  logic [VC-1:0] lnE;
  assign pxE = HC'(px);
  assign lnE = VC'(ln);

  // background plane: offset in steps of 4 pixels / 1 line (R5)
  logic [HC-1:0] bgX0;
  logic [VC-1:0] bgY0;
  logic          bgHit;
  assign bgX0  = HC'({cfg.bgH, 2'b00});
  assign bgY0  = VC'(cfg.bgV);
  assign bgHit = (pxE >= bgX0) && (pxE < bgX0 + HC'(BG_W)) &&
                 (lnE >= bgY0) && (lnE < bgY0 + VC'(BG_H));

  // inset windows: index 0 main, index 1 sub; 8-pixel steps (R6, R7)
  logic [1:0] winHit;
  logic [1:0] rimHit;

  for (genvar g = 0; g < 2; g++) begin : g_win
    localparam int WW = (g == 0) ? MAIN_W : SUB_W;
    localparam int WH = (g == 0) ? MAIN_H : SUB_H;
    logic [7:0] hPos;
    logic [7:0] vPos;
    assign hPos = (g == 0) ? cfg.mainH : cfg.subH;
    assign vPos = (g == 0) ? cfg.mainV : cfg.subV;

    pip_rect_decode #(
      .HC(HC), .VC(VC), .W(WW), .H(WH), .RIM_W(RIM_W), .RIM_H(RIM_H)
    ) u_dec (
      .px   (pxE),
      .ln   (lnE),
      .x0   (HC'({hPos, 3'b000})),
      .y0   (VC'(vPos)),
      .inWin(winHit[g]),
      .inRim(rimHit[g])
    );
  end

  // priority: main win > sub win > main rim > sub rim > background (R8)
  pipRegion_e rg;
  always_comb begin
    rg = RG_NONE;
    if (winHit[0])                      rg = RG_MAIN_WIN;
    else if (winHit[1])                 rg = RG_SUB_WIN;
    else if (cfg.borderOn && rimHit[0]) rg = RG_MAIN_RIM;
    else if (cfg.borderOn && rimHit[1]) rg = RG_SUB_RIM;
    else if (cfg.bgOn && bgHit)         rg = RG_BG;
  end

  // colour routing from the four slots (R9, R10)
  pipColour_t col;
  always_comb begin
    col = '0;
    case (rg)
      RG_MAIN_RIM: col = cfg.slot[SLOT_MAIN];
      RG_SUB_RIM:  col = cfg.subHilite ? cfg.slot[SLOT_HILITE] : cfg.slot[SLOT_SUB];
      RG_BG:       col = cfg.slot[SLOT_BG];
      default:     col = '0;
    endcase
  end

  assign region    = rg;
  assign colour    = col;
  assign fastBlank = (|winHit) | (cfg.borderOn & (|rimHit)) | (cfg.bgOn & bgHit);
endmodule

// File: rtl/pip_overlay.sv
module pip_overlay
  import pip_overlay_pkg::*;
#(
  parameter int PX_BITS = 12,
  parameter int LN_BITS = 10,
  parameter int BG_W    = 720,
  parameter int BG_H    = 240,
  parameter int MAIN_W  = 160,
  parameter int MAIN_H  = 60,
  parameter int SUB_W   = 120,
  parameter int SUB_H   = 40,
  parameter int RIM_W   = 8,
  parameter int RIM_H   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hSync,
  input  logic       vSync,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       fastBlank,
  output logic [2:0] region,
  output logic [4:0] colour
);
  pipStrobe_t strb;
  pipCfg_t    cfg;

  pip_overlay_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .hSync (hSync),
    .vSync (vSync),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strb  (strb),
    .cfg   (cfg)
  );

  pip_overlay_dp #(
    .PX_BITS(PX_BITS), .LN_BITS(LN_BITS), .BG_W(BG_W), .BG_H(BG_H),
    .MAIN_W(MAIN_W), .MAIN_H(MAIN_H), .SUB_W(SUB_W), .SUB_H(SUB_H),
    .RIM_W(RIM_W), .RIM_H(RIM_H)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfg      (cfg),
    .fastBlank(fastBlank),
    .region   (region),
    .colour   (colour)
  );
endmodule

// File: rtl/pip_overlay_chk.sv
module pip_overlay_chk
  import pip_overlay_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       vSync,
  input logic       fastBlank,
  input logic [2:0] region,
  input logic [4:0] colour,
  input pipCfg_t    cfg
);
  // live settings move only on a vertical sync edge
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !vSync |=> $stable(cfg));

  p_fb_region_r11: assert property (@(posedge clk) disable iff (!rstN)
    fastBlank == (region != RG_NONE));

  p_region_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    region <= RG_SUB_WIN);

  p_colour_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (region == RG_NONE || region == RG_MAIN_WIN || region == RG_SUB_WIN)
      |-> colour == 5'd0);

  p_bg_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.bgOn |-> region != RG_BG);

  p_rim_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.borderOn |-> (region != RG_MAIN_RIM && region != RG_SUB_RIM));

  p_hilite_r10: assert property (@(posedge clk) disable iff (!rstN)
    (region == RG_SUB_RIM && cfg.subHilite) |-> colour == cfg.slot[SLOT_HILITE]);
endmodule

bind pip_overlay pip_overlay_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .vSync    (vSync),
  .fastBlank(fastBlank),
  .region   (region),
  .colour   (colour),
  .cfg      (cfg)
);

// File: tb/pip_overlay_tb_top.sv
module pip_overlay_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hSync, vSync, wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic       fastBlank;
  logic [2:0] region;
  logic [4:0] colour;

  int  nChecks = 0;
  int  nBad    = 0;
  bit  finished = 1'b0;

  localparam logic [2:0] NONE = 3'd0, BG = 3'd1, MRIM = 3'd2, SRIM = 3'd3,
                         MWIN = 3'd4, SWIN = 3'd5;

  always #4 clk = ~clk;

  pip_overlay dut_i (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fastBlank(fastBlank), .region(region), .colour(colour)
  );

  task automatic sample(input logic [2:0] expRg, input logic [4:0] expCol,
                        input string req);
    logic expFb;
    expFb = (expRg != NONE);
    nChecks++;
    if (region !== expRg || colour !== expCol || fastBlank !== expFb) begin
      nBad++;
      $display("FAIL %s: region=%0d colour=%h fb=%b expected region=%0d colour=%h fb=%b",
               req, region, colour, fastBlank, expRg, expCol, expFb);
    end
  endtask

  // setting write through the port (R3)
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hLines(input int n);
    if (n > 0) begin
      hSync = 1'b1;
      repeat (n) @(negedge clk);
      hSync = 1'b0;
    end
  endtask

  // vertical sync, then n lines, then x pixels
  task automatic goTo(input int x, input int y);
    vSync = 1'b1;
    @(negedge clk);
    vSync = 1'b0;
    hLines(y);
    repeat (x) @(negedge clk);
  endtask

  task automatic expectAt(input int x, input int y, input logic [2:0] rg,
                          input logic [4:0] col, input string req);
    goTo(x, y);
    sample(rg, col, req);
  endtask

  task automatic t_reset();
    rstN = 1'b0; hSync = 0; vSync = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    repeat (3) @(negedge clk);
    sample(MWIN, 5'h00, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    sample(MWIN, 5'h00, "R1 after reset");
    expectAt(170, 5, NONE, 5'h00, "R1 main window only 160 wide");
  endtask

  task automatic t_defer();
    goTo(0, 0);
    wr(3'd3, 8'd20);   // main H -> x0 160
    wr(3'd4, 8'd10);   // main V -> y0 10
    wr(3'd5, 8'd30);   // sub H  -> x0 240
    wr(3'd6, 8'd20);   // sub V  -> y0 20
    hLines(5);
    repeat (5) @(negedge clk);
    sample(MWIN, 5'h00, "R4 old position before vsync");
    expectAt(5, 5, NONE, 5'h00, "R4 new position after vsync");
    expectAt(165, 12, MWIN, 5'h00, "R6 main window inside");
    hLines(1);                      // R2: px back to 0, line 13
    repeat (5) @(negedge clk);
    sample(NONE, 5'h00, "R2 hsync clears pixel count");
    repeat (160) @(negedge clk);
    sample(MWIN, 5'h00, "R2 line advanced, pixel 165");
    expectAt(159, 12, NONE, 5'h00, "R6 left edge");
    expectAt(319, 69, MWIN, 5'h00, "R6 last pixel");
    expectAt(320, 69, NONE, 5'h00, "R6 right edge");
    expectAt(200, 70, NONE, 5'h00, "R6 bottom edge");
  endtask

  task automatic t_bg();
    wr(3'd0, 8'h01);   // background on
    wr(3'd2, 8'h32);   // V 3, H 2 -> x0 8
    wr(3'd1, 8'h4A);   // slot 2: bright 1 type red (R3/R9)
    expectAt(8, 3, BG, 5'h0A, "R5 origin");
    expectAt(7, 3, NONE, 5'h00, "R5 left");
    expectAt(8, 2, NONE, 5'h00, "R5 top");
    expectAt(727, 3, BG, 5'h0A, "R5 last column");
    expectAt(728, 3, NONE, 5'h00, "R5 past width");
    expectAt(20, 242, BG, 5'h0A, "R5 last line");
    expectAt(20, 243, NONE, 5'h00, "R5 past height");
    expectAt(165, 12, MWIN, 5'h00, "R8 window over background");
  endtask

  task automatic t_rim();
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h19);   // slot 0 main rim
    wr(3'd1, 8'h26);   // slot 1 sub rim
    expectAt(152, 12, MRIM, 5'h19, "R7 left rim");
    expectAt(151, 12, BG, 5'h0A, "R7 outside left");
    expectAt(327, 12, MRIM, 5'h19, "R7 right rim");
    expectAt(328, 12, BG, 5'h0A, "R7 outside right");
    expectAt(200, 8, MRIM, 5'h19, "R7 top rim");
    expectAt(200, 7, BG, 5'h0A, "R7 above");
    expectAt(200, 71, MRIM, 5'h19, "R7 bottom rim");
    expectAt(200, 72, BG, 5'h0A, "R7 below");
  endtask

  task automatic t_prio();
    expectAt(300, 30, MWIN, 5'h00, "R8 main over sub");
    expectAt(330, 30, SWIN, 5'h00, "R8 sub window");
    expectAt(325, 30, SWIN, 5'h00, "R8 window over rim");
    expectAt(322, 19, MRIM, 5'h19, "R8 main rim over sub rim");
    expectAt(362, 30, SRIM, 5'h06, "R9 sub rim slot 1");
    expectAt(368, 30, BG, 5'h0A, "R9 background slot 2");
  endtask

  task automatic t_hilite();
    wr(3'd1, 8'h77);   // slot 3
    wr(3'd0, 8'h07);
    expectAt(362, 30, SRIM, 5'h17, "R10 highlight slot 3");
    expectAt(322, 19, MRIM, 5'h19, "R10 main rim untouched");
    wr(3'd0, 8'h03);
    expectAt(362, 30, SRIM, 5'h06, "R10 highlight off");
  endtask

  task automatic t_off();
    wr(3'd0, 8'h00);
    expectAt(152, 12, NONE, 5'h00, "R7 rims disabled");
    expectAt(362, 30, NONE, 5'h00, "R7 sub rim disabled");
    expectAt(8, 3, NONE, 5'h00, "R5 background disabled");
    wr(3'd0, 8'h01);
    expectAt(152, 12, BG, 5'h0A, "R11 background under disabled rim");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_defer();
    t_bg();
    t_rim();
    t_prio();
    t_hilite();
    t_off();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule